// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller with Spurious Vector

The block gathers eight interrupt request lines and drives one interrupt output to a processor. A low-to-high transition on an unmasked line sets that line's pending latch. The interrupt output then stays high even if the line falls again. When the processor strobes acknowledge, the controller chooses the highest-priority eligible pending line and returns an eight-bit vector one cycle later.

The vector is resolved against the live level of the chosen line at the moment of the acknowledge. If that line is still high, the controller serves it: the vector is the base plus the line index, the pending bit moves to in-service, and a later end-of-interrupt strobe retires it. If the line has already dropped, the controller reports a spurious interrupt. The spurious vector carries the lowest-priority index, so it is 0x27 at the reset base of 0x20 and 0x2F for a controller placed at base 0x28. In that case no in-service bit is set, and the pending latch that raised the request is discarded. The race needs only one cycle: the edge is captured, and the line falls on the same cycle as the acknowledge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A rising edge on an unmasked line sets its pending bit, and `irq_o` rises in the cycle after the edge is sampled. A line held high raises no second request until it has gone low and high again.
- R2: Once a line is pending, `irq_o` stays high after the line drops, until the request is taken by an acknowledge.
- R3: An acknowledge whose chosen line is still high produces `vec_valid_o` for exactly the following cycle. `vec_o` then equals base plus the line index, and the request moves to in-service.
- R4: Line 0 has the highest priority and line 7 the lowest. The lowest-numbered eligible pending line is the one chosen.
- R5: If the chosen line is low at the acknowledge, or nothing is eligible, `vec_o` is base plus 7. No in-service bit is set, and the chosen pending bit (if any) is cleared.
- R6: Writing the base stores bits 7..3 with bits 2..0 forced to zero. After reset the base is 0x20. At base 0x28 a spurious acknowledge returns 0x2F.
- R7: While a line is in service, pending requests of equal or lower priority do not assert `irq_o` and are not chosen. Higher-priority requests still assert it.
- R8: `eoi_i` clears the highest-priority in-service bit, which releases the lines it blocked.
- R9: A set mask bit prevents edges on that line from being captured. A request that is already pending is kept.
- R10: `rst_ni` low clears all pending, in-service and mask bits and `vec_valid_o`, and restores the base to 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Request lines, bit i is line i |
| mask_we_i | input | 1 | Load the mask register from mask_i |
| mask_i | input | 8 | New mask, 1 blocks capture on that line |
| base_we_i | input | 1 | Load the vector base from base_i |
| base_i | input | 8 | New vector base, bits 2..0 ignored |
| ack_i | input | 1 | One-cycle acknowledge strobe from the processor |
| eoi_i | input | 1 | One-cycle end-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte, valid with vec_valid_o |
| vec_valid_o | output | 1 | vec_o holds a new vector this cycle |

## Verification
The assertions take acknowledge and end-of-interrupt to be single-cycle strobes that are sampled synchronously. They also take request lines to be free of glitches within a cycle, so an edge is defined by two consecutive samples. The random stimulus toggles at most one line per cycle and keeps the two strobes to one cycle each. Some acknowledges arrive while nothing is eligible, and some arrive just after the chosen line has dropped, so the spurious path is covered. Directed sequences cover the one-cycle race, nested in-service blocking, masking and the relocated base.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LINES    = 8;
  localparam int unsigned VEC_W    = 8;
  localparam logic [7:0]  BASE_RST = 8'h20;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N_LINES = irq_pkg::LINES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] mask_i,
  output logic [N_LINES-1:0] edge_o
);
  logic [N_LINES-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign edge_o[i] = irq_i[i] & ~irq_q[i] & ~mask_i[i];

    // a held level never produces two captures in a row
    p_edge_one_shot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o[i] |=> !edge_o[i]);
  end
endmodule

// File: rtl/irq_prio_res.sv
module irq_prio_res #(
  parameter int unsigned N_LINES = irq_pkg::LINES,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [N_LINES-1:0] irq_i,
  output logic [N_LINES-1:0] elig_o,
  output logic               elig_any_o,
  output logic [N_LINES-1:0] cand_oh_o,
  output logic [IDX_W-1:0]   cand_idx_o,
  output logic               cand_live_o,
  output logic [N_LINES-1:0] isr_top_oh_o
);
  logic [N_LINES-1:0] above_isr;

  // lowest set bit of the in-service vector
  always_comb begin
    isr_top_oh_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--)
      if (isr_i[i]) isr_top_oh_o = '0 | (N_LINES'(1) << i);
  end

  // lines strictly above the top in-service line in priority
  assign above_isr  = (isr_top_oh_o == '0) ? '1 : isr_top_oh_o - N_LINES'(1);
  assign elig_o     = pend_i & above_isr;
  assign elig_any_o = |elig_o;

  always_comb begin
    cand_oh_o  = '0;
    cand_idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_o[i]) begin
        cand_oh_o  = N_LINES'(1) << i;
        cand_idx_o = IDX_W'(i);
      end
    end
  end

  assign cand_live_o = |(cand_oh_o & irq_i);

  always_comb begin
    p_cand_single_r4: assert ($onehot0(cand_oh_o));
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int unsigned N_LINES = irq_pkg::LINES,
  parameter int unsigned VEC_W   = irq_pkg::VEC_W,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] base_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic             elig_any_i,
  input  logic             cand_live_i,
  output logic             grant_o,
  output logic             spur_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  logic [VEC_W-1:0] vec_d;

  assign grant_o = ack_i & elig_any_i & cand_live_i;
  assign spur_o  = ack_i & ~(elig_any_i & cand_live_i);
  assign vec_d   = grant_o ? {base_i[VEC_W-1:IDX_W], cand_idx_i}
                           : {base_i[VEC_W-1:IDX_W], {IDX_W{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_d;
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int unsigned N_LINES  = irq_pkg::LINES,
  parameter int unsigned VEC_W    = irq_pkg::VEC_W,
  parameter logic [VEC_W-1:0] BASE_RST = irq_pkg::BASE_RST,
  localparam int unsigned IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               mask_we_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               base_we_i,
  input  logic [VEC_W-1:0]   base_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  logic [N_LINES-1:0] pend_q, isr_q, mask_q;
  logic [VEC_W-1:0]   base_q;
  logic [N_LINES-1:0] edge_w, elig_w, cand_oh_w, isr_top_w;
  logic [IDX_W-1:0]   cand_idx_w;
  logic               elig_any_w, cand_live_w, grant_w, spur_w;
  logic [N_LINES-1:0] pend_clr, isr_set, isr_clr;

  irq_edge_det #(.N_LINES(N_LINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .mask_i (mask_q),
    .edge_o (edge_w)
  );

  irq_prio_res #(.N_LINES(N_LINES)) u_prio (
    .pend_i       (pend_q),
    .isr_i        (isr_q),
    .irq_i        (irq_i),
    .elig_o       (elig_w),
    .elig_any_o   (elig_any_w),
    .cand_oh_o    (cand_oh_w),
    .cand_idx_o   (cand_idx_w),
    .cand_live_o  (cand_live_w),
    .isr_top_oh_o (isr_top_w)
  );

  irq_vec_gen #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .base_i      (base_q),
    .cand_idx_i  (cand_idx_w),
    .elig_any_i  (elig_any_w),
    .cand_live_i (cand_live_w),
    .grant_o     (grant_w),
    .spur_o      (spur_w),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

  // an acknowledge always consumes the chosen latch, served or spurious
  assign pend_clr = (ack_i && elig_any_w) ? cand_oh_w : '0;
  assign isr_set  = grant_w ? cand_oh_w : '0;
  assign isr_clr  = eoi_i ? isr_top_w : '0;
  assign irq_o    = elig_any_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= BASE_RST & ~VEC_W'((1 << IDX_W) - 1);
    end else begin
      pend_q <= (pend_q & ~pend_clr) | edge_w;
      isr_q  <= (isr_q & ~isr_clr) | isr_set;
      if (mask_we_i) mask_q <= mask_i;
      if (base_we_i) base_q <= {base_i[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_hold
    p_pend_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[i] && !ack_i) |=> pend_q[i]);
  end

  p_spur_no_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spur_w && !eoi_i) |=> (isr_q == $past(isr_q)));

  p_eoi_retire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_i && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic [7:0] irq, mask_d, base_d;
  logic       mask_we, base_we, ack, eoi;
  logic       irq_out, vvalid;
  logic [7:0] vec;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_we_i(mask_we), .mask_i(mask_d),
    .base_we_i(base_we), .base_i(base_d), .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq_out), .vec_o(vec), .vec_valid_o(vvalid)
  );

  logic [7:0] m_pend, m_isr, m_mask, m_base, m_prev, m_vec;
  logic       m_valid;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [7:0] lowest(input logic [7:0] v);
    return v & (~v + 8'd1);
  endfunction
  function automatic logic [7:0] above(input logic [7:0] s);
    logic [7:0] l;
    l = lowest(s);
    return (l == 8'd0) ? 8'hff : l - 8'd1;
  endfunction
  function automatic logic [2:0] idx_of(input logic [7:0] oh);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 8; i++) if (oh[i]) r = 3'(i);
    return r;
  endfunction

  task automatic model_reset();
    m_pend = 0; m_isr = 0; m_mask = 0; m_base = 8'h20; m_prev = 0;
    m_vec = 0; m_valid = 0;
  endtask

  task automatic model_step();
    logic [7:0] el, c, edg;
    el  = m_pend & above(m_isr);
    c   = lowest(el);
    edg = irq & ~m_prev & ~m_mask;
    m_valid = ack;
    if (ack) begin
      if (c != 0 && (irq & c) != 0) begin
        m_vec = {m_base[7:3], idx_of(c)};
        m_isr = m_isr | c;
      end else m_vec = {m_base[7:3], 3'b111};
      m_pend = m_pend & ~c;
    end
    if (eoi) m_isr = m_isr & ~lowest(m_isr & ~((ack && c != 0 && (irq & c) != 0) ? c : 8'd0));
    m_pend = m_pend | edg;
    if (mask_we) m_mask = mask_d;
    if (base_we) m_base = {base_d[7:3], 3'b000};
    m_prev = irq;
  endtask

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
    #1;
    chk(tag, "irq_o", {7'd0, irq_out}, {7'd0, |(m_pend & above(m_isr))});
    chk(tag, "vec_valid_o", {7'd0, vvalid}, {7'd0, m_valid});
    if (m_valid) chk(tag, "vec_o", vec, m_vec);
    ack = 0; eoi = 0; mask_we = 0; base_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    chk("R10", "irq_o in reset", {7'd0, irq_out}, 8'd0);
    chk("R10", "vec_valid_o in reset", {7'd0, vvalid}, 8'd0);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    irq = 0; mask_d = 0; base_d = 0; mask_we = 0; base_we = 0; ack = 0; eoi = 0;
    do_reset();
    tick("R10");
    // R1: edge raises irq_o one cycle later; held level does not retrigger
    irq = 8'h04; tick("R1");
    chk("R1", "irq after edge", {7'd0, irq_out}, 8'd1);
    ack = 1; tick("R1");
    tick("R1");
    chk("R1", "vec line2", vec, 8'h22);
    repeat (3) tick("R1");
    chk("R1", "held level no retrigger", {7'd0, irq_out}, 8'd0);
    eoi = 1; tick("R8");
    irq = 0; tick("R1");
    // R2: latch survives line drop
    irq = 8'h10; tick("R2"); irq = 0; tick("R2"); tick("R2");
    chk("R2", "latched after drop", {7'd0, irq_out}, 8'd1);
    // R5: pending line low at ack -> spurious 0x27, no in-service
    ack = 1; tick("R5"); tick("R5");
    chk("R5", "spurious vector", vec, 8'h27);
    chk("R5", "latch consumed", {7'd0, irq_out}, 8'd0);
    // R5: one-cycle race on line 0
    irq = 8'h01; tick("R5");
    irq = 8'h00; ack = 1; tick("R5"); tick("R5");
    chk("R5", "race spurious", vec, 8'h27);
    // R4/R3: two lines, lowest served first
    irq = 8'h28; tick("R4");
    ack = 1; tick("R4"); tick("R4");
    chk("R4", "line3 first", vec, 8'h23);
    // R7: line5 lower priority than in-service line3: blocked
    chk("R7", "lower blocked", {7'd0, irq_out}, 8'd0);
    irq = 8'h2a; tick("R7");
    chk("R7", "higher passes", {7'd0, irq_out}, 8'd1);
    ack = 1; tick("R3"); tick("R3");
    chk("R3", "line1 nested", vec, 8'h21);
    // R8: eoi retires line1 then line3, releasing line5
    eoi = 1; tick("R8");
    chk("R8", "line3 still blocks", {7'd0, irq_out}, 8'd0);
    eoi = 1; tick("R8");
    chk("R8", "line5 released", {7'd0, irq_out}, 8'd1);
    ack = 1; tick("R8"); tick("R8");
    chk("R8", "line5 vec", vec, 8'h25);
    eoi = 1; tick("R8");
    irq = 0; tick("R9");
    // R9: masked line ignored
    mask_d = 8'h40; mask_we = 1; tick("R9");
    irq = 8'h40; tick("R9"); tick("R9");
    chk("R9", "masked no irq", {7'd0, irq_out}, 8'd0);
    irq = 0; mask_d = 0; mask_we = 1; tick("R9");
    // R6: relocated base, low bits dropped
    base_d = 8'h2d; base_we = 1; tick("R6");
    ack = 1; tick("R6"); tick("R6");
    chk("R6", "secondary spurious", vec, 8'h2f);
    irq = 8'h01; tick("R6");
    ack = 1; tick("R6"); tick("R6");
    chk("R6", "base 0x28 line0", vec, 8'h28);
    eoi = 1; irq = 0; tick("R6");
    // R10: mid-run reset restores base 0x20 and clears mask
    mask_d = 8'hff; mask_we = 1; irq = 8'h80; tick("R10");
    do_reset();
    tick("R10");
    irq = 8'h00; tick("R10");
    irq = 8'h80; tick("R10");
    chk("R10", "mask cleared", {7'd0, irq_out}, 8'd1);
    ack = 1; tick("R10"); tick("R10");
    chk("R10", "base restored", vec, 8'h27);
    eoi = 1; tick("R10");
    // random mix, checked against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 == 0) irq = irq ^ (8'd1 << ($urandom % 8));
      ack = ($urandom % 5 == 0);
      eoi = ($urandom % 6 == 0);
      if ($urandom % 80 == 0) begin mask_we = 1; mask_d = 8'($urandom) & 8'h3c; end
      if ($urandom % 300 == 0) begin base_we = 1; base_d = 8'($urandom); end
      tick("R4");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule